// File: doc/BRIEF.md
# Hardwired Instruction-Cycle Sequencer

This block is the control unit and register datapath of a small processor with one accumulator. A two-bit cycle code selects one of four phases: fetch, indirect, execute and interrupt. A step counter inside each phase issues steps t1 to t4, and each step carries out a fixed group of register transfers among the program counter, memory address register, memory buffer register, instruction register and accumulator. The control is hardwired: the control word comes from combinational decoding of the phase, the step, the opcode and a zero flag.

Memory is a word-addressed synchronous port. The block drives an address taken from the memory address register and data taken from the buffer register. Read data arrives in the same cycle the read strobe is high and is captured into the buffer register at the end of that step. Three memory-reference instructions are decoded: add to accumulator, increment-and-skip-if-zero, and branch-and-save-return-address. An interrupt request is taken between instructions. It saves the program counter to a fixed word and jumps to a fixed service address.

Top module: `hwcu_top`

## Requirements
- R1: During and after reset the program counter and accumulator read 0, the cycle code is fetch (00), the step is t1 (0), both memory strobes are low and interrupt acceptance is enabled.
- R2: The cycle code uses fetch=00, indirect=01, execute=10, interrupt=11. The step output counts 0,1,2,... inside a phase and returns to 0 in the first cycle of every new phase.
- R3: Fetch takes three steps. In t2 the read strobe is high with the address equal to the program counter value held at t1, and the program counter advances by one. The word read becomes the instruction at t3.
- R4: An instruction word has the opcode in bits [15:13] (000 add, 001 increment-and-skip, 010 branch-and-save), the indirect flag in bit 12 and the address in bits [11:0]. After fetch the phase goes to indirect when bit 12 is 1 and to execute otherwise.
- R5: Indirect takes three steps with a read in t2. The effective address becomes bits [11:0] of the word at the instruction address, and execute then behaves as if that address had been given directly.
- R6: Add takes three execute steps with a read in t2. The accumulator becomes the accumulator plus the operand, modulo 2^16.
- R7: Increment-and-skip takes four execute steps: a read in t2 and a write in t4 of the operand plus one (modulo 2^16). When the written value is 0, the program counter advances once more, so the next instruction is skipped.
- R8: Branch-and-save takes three execute steps with a write in t2. The effective address receives the address of the following instruction, zero-extended. Execution resumes at the effective address plus one.
- R9: At the end of execute, if a request is present and acceptance is enabled, the interrupt phase runs for three steps. It writes the program counter (zero-extended) to the save word in t3 and loads the service address. Entering this phase disables acceptance, so later requests leave the phase sequence unchanged.
- R10: No cycle raises the read and write strobes together, and reads occur only in step t2.
- R11: Opcodes 011 to 111 run three execute steps with no memory access and no change to the program counter or the accumulator. The indirect flag is still honoured for these opcodes.
- R12: Only the increment-and-skip execute phase reaches t4; every other phase ends after t3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-flop synchronizer |
| irq | input | 1 | Interrupt request, sampled at the last execute step |
| mem_rdata | input | 16 | Read data for the word at mem_addr |
| mem_addr | output | 12 | Word address (memory address register) |
| mem_wdata | output | 16 | Write data (memory buffer register) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe, committed at the next rising edge |
| pc_o | output | 12 | Program counter |
| acc_o | output | 16 | Accumulator |
| cyc_o | output | 2 | Current cycle code |
| step_o | output | 2 | Current step inside the phase (0 = t1) |

## Verification
In step t4 of increment-and-skip, the memory write-back and the conditional program-counter skip happen in the same cycle. Both are driven by the freshly incremented buffer value. The bench provokes this with a counter that reaches zero (one direct, one through a pointer) and with one that does not. It then judges the result by the address of the next fetch and by the final memory image. The other pair is the fetch read in t2 together with the increment of the program counter. This is judged by comparing the read address against the counter value from the step before, and the next instruction address against the reference model.

// File: rtl/hwcu_pkg.sv
`timescale 1ns/1ps
package hwcu_pkg;

  localparam int STEP_W = 2;
  localparam int OPC_W  = 3;

  typedef enum logic [1:0] {
    CYC_FETCH = 2'b00,
    CYC_IND   = 2'b01,
    CYC_EXEC  = 2'b10,
    CYC_INT   = 2'b11
  } cyc_e;

  localparam logic [STEP_W-1:0] T1 = 2'd0;
  localparam logic [STEP_W-1:0] T2 = 2'd1;
  localparam logic [STEP_W-1:0] T3 = 2'd2;
  localparam logic [STEP_W-1:0] T4 = 2'd3;

  localparam logic [OPC_W-1:0] OP_ADD = 3'b000;
  localparam logic [OPC_W-1:0] OP_ISZ = 3'b001;
  localparam logic [OPC_W-1:0] OP_BSA = 3'b010;

  // one bit per register transfer or strobe in the current step
  typedef struct packed {
    logic mar_pc;
    logic mar_ir;
    logic mar_save;
    logic mbr_mem;
    logic mbr_pc;
    logic mbr_inc;
    logic pc_inc;
    logic pc_ir;
    logic pc_isr;
    logic ir_all;
    logic ir_addr;
    logic acc_add;
    logic rd;
    logic wr;
    logic last;
  } ctl_t;

endpackage

// File: rtl/hwcu_timer.sv
`timescale 1ns/1ps
module hwcu_timer
  import hwcu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              last,
  output logic [STEP_W-1:0] step
);

  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] step_d;

  always_comb begin
    if (last) step_d = T1;
    else      step_d = step_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= T1;
    else        step_q <= step_d;
  end

  assign step = step_q;

endmodule

// File: rtl/hwcu_phase.sv
`timescale 1ns/1ps
module hwcu_phase
  import hwcu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic last,
  input  logic ind_bit,
  input  logic irq,
  output cyc_e cyc,
  output logic ien
);

  cyc_e cyc_q, cyc_d;
  logic ien_q, ien_d;
  logic cyc_en;

  always_comb begin
    cyc_en = last;
    cyc_d  = cyc_q;
    ien_d  = ien_q;
    unique case (cyc_q)
      CYC_FETCH: cyc_d = ind_bit ? CYC_IND : CYC_EXEC;
      CYC_IND:   cyc_d = CYC_EXEC;
      CYC_EXEC: begin
        if (irq && ien_q) begin
          cyc_d = CYC_INT;
          ien_d = 1'b0;
        end else begin
          cyc_d = CYC_FETCH;
        end
      end
      CYC_INT:   cyc_d = CYC_FETCH;
      default:   cyc_d = CYC_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= CYC_FETCH;
      ien_q <= 1'b1;
    end else if (cyc_en) begin
      cyc_q <= cyc_d;
      ien_q <= ien_d;
    end
  end

  assign cyc = cyc_q;
  assign ien = ien_q;

endmodule

// File: rtl/hwcu_decode.sv
`timescale 1ns/1ps
module hwcu_decode
  import hwcu_pkg::*;
(
  input  cyc_e              cyc,
  input  logic [STEP_W-1:0] step,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              mbr_zero,
  output ctl_t              ctl
);

  always_comb begin
    ctl = '0;
    unique case (cyc)
      CYC_FETCH: begin
        unique case (step)
          T1: ctl.mar_pc = 1'b1;
          T2: begin
            ctl.rd      = 1'b1;
            ctl.mbr_mem = 1'b1;
            ctl.pc_inc  = 1'b1;
          end
          default: begin
            ctl.ir_all = 1'b1;
            ctl.last   = 1'b1;
          end
        endcase
      end
      CYC_IND: begin
        unique case (step)
          T1: ctl.mar_ir = 1'b1;
          T2: begin
            ctl.rd      = 1'b1;
            ctl.mbr_mem = 1'b1;
          end
          default: begin
            ctl.ir_addr = 1'b1;
            ctl.last    = 1'b1;
          end
        endcase
      end
      CYC_EXEC: begin
        if (opcode == OP_BSA) begin
          unique case (step)
            T1: begin
              ctl.mar_ir = 1'b1;
              ctl.mbr_pc = 1'b1;
            end
            T2: begin
              ctl.wr    = 1'b1;
              ctl.pc_ir = 1'b1;
            end
            default: begin
              ctl.pc_inc = 1'b1;
              ctl.last   = 1'b1;
            end
          endcase
        end else if (opcode == OP_ADD || opcode == OP_ISZ) begin
          unique case (step)
            T1: ctl.mar_ir = 1'b1;
            T2: begin
              ctl.rd      = 1'b1;
              ctl.mbr_mem = 1'b1;
            end
            T3: begin
              if (opcode == OP_ADD) begin
                ctl.acc_add = 1'b1;
                ctl.last    = 1'b1;
              end else begin
                ctl.mbr_inc = 1'b1;
              end
            end
            default: begin
              ctl.wr     = 1'b1;
              ctl.pc_inc = mbr_zero;
              ctl.last   = 1'b1;
            end
          endcase
        end else begin
          ctl.last = (step == T3);
        end
      end
      default: begin
        unique case (step)
          T1: ctl.mbr_pc = 1'b1;
          T2: begin
            ctl.mar_save = 1'b1;
            ctl.pc_isr   = 1'b1;
          end
          default: begin
            ctl.wr   = 1'b1;
            ctl.last = 1'b1;
          end
        endcase
      end
    endcase
  end

endmodule

// File: rtl/hwcu_datapath.sv
`timescale 1ns/1ps
module hwcu_datapath
  import hwcu_pkg::*;
#(
  parameter int                DATA_W    = 16,
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] ISR_ADDR  = 12'h100,
  parameter logic [ADDR_W-1:0] SAVE_ADDR = 12'h0FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [OPC_W-1:0]  opcode,
  output logic              ind_bit,
  output logic              mbr_zero,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] acc
);

  localparam int PAD_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] pc_q, pc_d, mar_q, mar_d;
  logic [DATA_W-1:0] mbr_q, mbr_d, ir_q, ir_d, acc_q, acc_d;
  logic              pc_en, mar_en, mbr_en, ir_en, acc_en;

  always_comb begin
    pc_en = ctl.pc_inc | ctl.pc_ir | ctl.pc_isr;
    if (ctl.pc_isr)     pc_d = ISR_ADDR;
    else if (ctl.pc_ir) pc_d = ir_q[ADDR_W-1:0];
    else                pc_d = pc_q + 1'b1;

    mar_en = ctl.mar_pc | ctl.mar_ir | ctl.mar_save;
    if (ctl.mar_save)    mar_d = SAVE_ADDR;
    else if (ctl.mar_ir) mar_d = ir_q[ADDR_W-1:0];
    else                 mar_d = pc_q;

    mbr_en = ctl.mbr_mem | ctl.mbr_pc | ctl.mbr_inc;
    if (ctl.mbr_mem)     mbr_d = mem_rdata;
    else if (ctl.mbr_pc) mbr_d = {{PAD_W{1'b0}}, pc_q};
    else                 mbr_d = mbr_q + 1'b1;

    ir_en = ctl.ir_all | ctl.ir_addr;
    if (ctl.ir_all) ir_d = mbr_q;
    else            ir_d = {ir_q[DATA_W-1:ADDR_W], mbr_q[ADDR_W-1:0]};

    acc_en = ctl.acc_add;
    acc_d  = acc_q + mbr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mar_q <= '0;
    else if (mar_en) mar_q <= mar_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mbr_q <= '0;
    else if (mbr_en) mbr_q <= mbr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ir_q <= '0;
    else if (ir_en) ir_q <= ir_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mbr_q;
  assign opcode    = ir_q[DATA_W-1 -: OPC_W];
  assign ind_bit   = mbr_q[ADDR_W];
  assign mbr_zero  = (mbr_q == '0);
  assign pc        = pc_q;
  assign acc       = acc_q;

endmodule

// File: rtl/hwcu_top.sv
`timescale 1ns/1ps
module hwcu_top
  import hwcu_pkg::*;
#(
  parameter int                DATA_W    = 16,
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] ISR_ADDR  = 12'h100,
  parameter logic [ADDR_W-1:0] SAVE_ADDR = 12'h0FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [1:0]        cyc_o,
  output logic [1:0]        step_o
);

  logic              rst_meta_q, rst_sync_n;
  ctl_t              ctl;
  cyc_e              cyc;
  logic [STEP_W-1:0] step;
  logic [OPC_W-1:0]  opcode;
  logic              ind_bit, mbr_zero, irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  hwcu_timer u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .last  (ctl.last),
    .step  (step)
  );

  hwcu_phase u_phase (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .last    (ctl.last),
    .ind_bit (ind_bit),
    .irq     (irq),
    .cyc     (cyc),
    .ien     (irq_en)
  );

  hwcu_decode u_decode (
    .cyc      (cyc),
    .step     (step),
    .opcode   (opcode),
    .mbr_zero (mbr_zero),
    .ctl      (ctl)
  );

  hwcu_datapath #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .ISR_ADDR  (ISR_ADDR),
    .SAVE_ADDR (SAVE_ADDR)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ctl       (ctl),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .opcode    (opcode),
    .ind_bit   (ind_bit),
    .mbr_zero  (mbr_zero),
    .pc        (pc_o),
    .acc       (acc_o)
  );

  assign mem_rd = ctl.rd;
  assign mem_wr = ctl.wr;
  assign cyc_o  = cyc;
  assign step_o = step;

endmodule

// File: rtl/hwcu_checker.sv
`timescale 1ns/1ps
module hwcu_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cyc,
  input logic [1:0]        step,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] pc,
  input logic              irq,
  input logic              ien
);

  a_r10_no_rd_wr: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r10_rd_in_t2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (step == 2'd1));

  a_r2_step_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != $past(cyc)) |-> (step == 2'd0));

  a_r4_fetch_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc != $past(cyc)) && ($past(cyc) == 2'b00)) |-> (cyc == 2'b01 || cyc == 2'b10));

  a_r3_fetch_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'b00 && step == 2'd1) |-> (mem_addr == $past(pc)));

  a_r9_int_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'b11 && $past(cyc) == 2'b10) |-> ($past(irq) && $past(ien)));

  a_r9_ien_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(ien));

  a_r9_ien_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ien) |-> (cyc == 2'b11));

  a_r12_t4_exec_only: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 2'd3) |-> (cyc == 2'b10));

endmodule

bind hwcu_top hwcu_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .cyc      (cyc_o),
  .step     (step_o),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .mem_addr (mem_addr),
  .pc       (pc_o),
  .irq      (irq),
  .ien      (irq_en)
);

// File: tb/hwcu_top_bench.sv
`timescale 1ns/1ps
module hwcu_top_bench;

  localparam int          AW     = 12;
  localparam int          DW     = 16;
  localparam logic [11:0] ISR    = 12'h100;
  localparam logic [11:0] SAVE   = 12'h0FF;
  localparam int          NINSTR = 14;
  localparam int          IRQ_K  = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          irq;
  logic [DW-1:0] mem_rdata, mem_wdata, acc_o;
  logic [AW-1:0] mem_addr, pc_o;
  logic          mem_rd, mem_wr;
  logic [1:0]    cyc_o, step_o;

  always #2.5 clk = ~clk;

  hwcu_top u_hwcu_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .pc_o      (pc_o),
    .acc_o     (acc_o),
    .cyc_o     (cyc_o),
    .step_o    (step_o)
  );

  logic [DW-1:0] mem     [0:4095];
  logic [DW-1:0] ref_mem [0:4095];

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // reference model state
  logic [AW-1:0] mpc;
  logic [DW-1:0] macc;
  logic          mien;
  logic [5:0]    rq[$];
  string         last_tag;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic put(input logic [11:0] a, input logic [15:0] v);
    mem[a] = v;
    ref_mem[a] = v;
  endtask

  task automatic push(input logic [1:0] c, input logic [1:0] s,
                      input logic rd, input logic wr);
    rq.push_back({c, s, rd, wr});
  endtask

  // builds the expected cycle records of one instruction and updates the model
  task automatic model_instr(input logic req);
    logic [15:0] w, v;
    logic [11:0] ea;
    logic [2:0]  op;
    string       tag;
    push(2'b00, 2'd0, 0, 0); push(2'b00, 2'd1, 1, 0); push(2'b00, 2'd2, 0, 0);
    w   = ref_mem[mpc];
    mpc = mpc + 1'b1;
    op  = w[15:13];
    ea  = w[11:0];
    tag = "";
    if (w[12]) begin
      push(2'b01, 2'd0, 0, 0); push(2'b01, 2'd1, 1, 0); push(2'b01, 2'd2, 0, 0);
      ea  = ref_mem[ea][11:0];
      tag = "R5 ";
    end
    case (op)
      3'b000: begin
        push(2'b10, 2'd0, 0, 0); push(2'b10, 2'd1, 1, 0); push(2'b10, 2'd2, 0, 0);
        macc = macc + ref_mem[ea];
        tag  = {tag, "R6"};
      end
      3'b001: begin
        push(2'b10, 2'd0, 0, 0); push(2'b10, 2'd1, 1, 0);
        push(2'b10, 2'd2, 0, 0); push(2'b10, 2'd3, 0, 1);
        v = ref_mem[ea] + 1'b1;
        ref_mem[ea] = v;
        if (v == 16'h0) mpc = mpc + 1'b1;
        tag = {tag, "R7"};
      end
      3'b010: begin
        push(2'b10, 2'd0, 0, 0); push(2'b10, 2'd1, 0, 1); push(2'b10, 2'd2, 0, 0);
        ref_mem[ea] = {4'h0, mpc};
        mpc = ea + 1'b1;
        tag = {tag, "R8"};
      end
      default: begin
        push(2'b10, 2'd0, 0, 0); push(2'b10, 2'd1, 0, 0); push(2'b10, 2'd2, 0, 0);
        tag = {tag, "R11"};
      end
    endcase
    if (req && mien) begin
      push(2'b11, 2'd0, 0, 0); push(2'b11, 2'd1, 0, 0); push(2'b11, 2'd2, 0, 1);
      ref_mem[SAVE] = {4'h0, mpc};
      mpc  = ISR;
      mien = 1'b0;
      tag  = {tag, " R9"};
    end
    last_tag = tag;
  endtask

  initial begin : main
    logic [5:0]  r;
    logic [11:0] fpc;
    bit          first;
    irq   = 1'b0;
    rst_n = 1'b0;
    for (int i = 0; i < 4096; i++) put(i[11:0], 16'h0);
    // program
    put(12'h000, 16'h0020); // add 020
    put(12'h001, 16'h1021); // add via pointer at 021
    put(12'h002, 16'h2023); // isz 023 (no skip)
    put(12'h003, 16'h2023); // isz 023 (skip)
    put(12'h004, 16'h0020); // skipped
    put(12'h005, 16'h4030); // bsa 030
    put(12'h031, 16'h0024); // add 024
    put(12'h032, 16'h3025); // isz via pointer at 025 (skip)
    put(12'h033, 16'hE000); // skipped
    put(12'h034, 16'h7000); // undefined opcode, indirect
    put(12'h035, 16'h0020); // add 020, request taken here
    put(12'h100, 16'h0027); // add 027, request ignored
    put(12'h101, 16'h5028); // bsa via pointer at 028
    // data
    put(12'h020, 16'h0005); put(12'h021, 16'h0022); put(12'h022, 16'h0007);
    put(12'h023, 16'hFFFE); put(12'h024, 16'h8000); put(12'h025, 16'h0026);
    put(12'h026, 16'hFFFF); put(12'h027, 16'hFFF0); put(12'h028, 16'h0040);
    mpc = '0; macc = '0; mien = 1'b1; last_tag = "R1";

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "reset pc", pc_o, 0);
    check("R1", "reset acc", acc_o, 0);
    check("R1", "reset phase/step", {cyc_o, step_o}, 0);
    check("R1", "reset strobes", {mem_rd, mem_wr}, 0);
    @(negedge clk);

    for (int k = 0; k < NINSTR; k++) begin
      irq = (k == IRQ_K) || (k == IRQ_K + 1);
      check(last_tag, "pc at instruction start", pc_o, mpc);
      check(last_tag, "accumulator at instruction start", acc_o, macc);
      fpc = mpc;
      model_instr(irq);
      first = 1;
      while (rq.size() > 0) begin
        r = rq.pop_front();
        if (!first) @(negedge clk);
        first = 0;
        check("R2/R4/R12", "phase,step", {cyc_o, step_o}, r[5:2]);
        check("R10", "read,write strobes", {mem_rd, mem_wr}, r[1:0]);
        if (r[5:2] == 4'b0001) check("R3", "fetch address", mem_addr, fpc);
      end
      @(negedge clk);
    end
    check(last_tag, "final pc", pc_o, mpc);
    check(last_tag, "final accumulator", acc_o, macc);
    for (int a = 0; a < 512; a++)
      check("R7/R8/R9", $sformatf("memory word %0h", a), mem[a], ref_mem[a]);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule